// File: doc/BRIEF.md
# Dual-Pool Physical Register Free List

This block keeps track of which physical registers are free for a register-renaming stage. Integer and floating-point registers share one physical index space. Indices below `INT_PHYS` belong to the integer class. Indices from `INT_PHYS` up to `INT_PHYS+FP_PHYS-1` belong to the floating-point class. Each class has its own first-in first-out pool. Each pool has a single-entry allocate port that hands out and removes the oldest free index.

Freed registers come back on one of three ports. A generic release port sorts each index into its pool by value. It drops the hard-wired zero register of either class and ignores indices beyond the index space. Two direct release ports, one per pool, push any value into that pool with no filtering. Each pool reports a not-empty flag and a free count. Two sticky error flags record illegal traffic: allocating from an empty pool, and releasing into a full pool (a double free). Both flags clear only on reset.

Top module: `regfree_list`

## Requirements
- R1: After reset, the integer pool holds indices `INT_LOG` through `INT_PHYS-1` in ascending order, and the floating-point pool holds `INT_PHYS+FP_LOG` through `INT_PHYS+FP_PHYS-1` in ascending order. With the defaults these are 8..15 (count 8) and 22..27 (count 6). Both error flags are low.
- R2: While a pool is not empty, its allocate index output shows the oldest entry. Asserting the pool's allocate request for one cycle removes that entry, and the next-oldest entry then appears on the output.
- R3: On the generic release port, an index below `INT_PHYS` is appended to the integer pool. An index from `INT_PHYS` to `INT_PHYS+FP_PHYS-1` is appended to the floating-point pool. A larger index (28..31 with the defaults) changes neither pool.
- R4: On the generic release port, index `ZERO_REG` (default 0) is not added to the integer pool, and index `ZERO_REG+INT_PHYS` (default 16) is not added to the floating-point pool.
- R5: The direct integer and floating-point release ports append the given index to their own pool whatever its value, including zero-register and other-class indices.
- R6: When the generic port and a pool's direct port both release into the same pool in one cycle, the generic index is queued ahead of the direct index.
- R7: Each pool's not-empty flag is high exactly when its free count is non-zero. The count equals the number of entries queued.
- R8: An allocate request to an empty pool sets the sticky `underflow_err` flag and removes nothing. The flag stays high until reset.
- R9: A release that would take a pool beyond its physical register count sets the sticky `overflow_err` flag and is dropped. When two releases arrive together and only one fits, the direct one is dropped.
- R10: An allocation and a release to the same non-empty pool in one cycle are both carried out, and the count is unchanged. When the pool was empty, the allocation fails under R8, the release is queued, and the count becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_alloc_req | input | 1 | Take the oldest integer index |
| int_alloc_idx | output | IDX_W | Oldest free integer index |
| fp_alloc_req | input | 1 | Take the oldest floating-point index |
| fp_alloc_idx | output | IDX_W | Oldest free floating-point index |
| rel_vld | input | 1 | Generic release valid |
| rel_idx | input | IDX_W | Generic release index, routed by value |
| int_rel_vld | input | 1 | Direct integer release valid |
| int_rel_idx | input | IDX_W | Direct integer release index |
| fp_rel_vld | input | 1 | Direct floating-point release valid |
| fp_rel_idx | input | IDX_W | Direct floating-point release index |
| int_not_empty | output | 1 | Integer pool holds at least one entry |
| int_free_cnt | output | clog2(INT_PHYS+1) | Integer pool entry count |
| fp_not_empty | output | 1 | Floating-point pool holds at least one entry |
| fp_free_cnt | output | clog2(FP_PHYS+1) | Floating-point pool entry count |
| underflow_err | output | 1 | Sticky: allocation from an empty pool |
| overflow_err | output | 1 | Sticky: release into a full pool |

## Verification
The hardest cases to reach are at the pool boundaries. One is an allocation and a release to a pool that is empty at that moment. The other is two releases into a pool with room for only one. The stimulus drains the floating-point pool by allocating until its count reads zero, then allocates with no release, and then allocates with a simultaneous direct release. It fills the integer pool with direct releases until it is one short of full, then fires the generic and direct ports together so that exactly one entry is dropped. A long stretch of random mixed traffic follows, and a queue-based model checks every pool output and flag on every cycle.

// File: rtl/regfree_pkg.sv
`timescale 1ns/1ps
package regfree_pkg;

  typedef enum logic [1:0] {
    CLS_DROP = 2'd0,
    CLS_INT  = 2'd1,
    CLS_FP   = 2'd2
  } rel_cls_e;

  // Sort a released index into its pool, filtering the two zero registers.
  function automatic rel_cls_e classify(input int unsigned idx,
                                        input int unsigned int_phys,
                                        input int unsigned total,
                                        input int unsigned zero_reg);
    rel_cls_e cls;
    if (idx < int_phys) begin
      cls = (idx == zero_reg) ? CLS_DROP : CLS_INT;
    end else if (idx < total) begin
      cls = (idx == zero_reg + int_phys) ? CLS_DROP : CLS_FP;
    end else begin
      cls = CLS_DROP;
    end
    return cls;
  endfunction

endpackage

// File: rtl/regfree_router.sv
`timescale 1ns/1ps
module regfree_router
  import regfree_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int INT_PHYS = 16,
  parameter int FP_PHYS  = 12,
  parameter int ZERO_REG = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rel_vld,
  input  logic [IDX_W-1:0] rel_idx,
  output logic             to_int_vld,
  output logic             to_fp_vld
);

  localparam int TOTAL = INT_PHYS + FP_PHYS;

  rel_cls_e cls;

  always_comb begin
    cls        = classify(int'(rel_idx), INT_PHYS, TOTAL, ZERO_REG);
    to_int_vld = rel_vld && (cls == CLS_INT);
    to_fp_vld  = rel_vld && (cls == CLS_FP);
  end

  // R3
  route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({to_int_vld, to_fp_vld}));

  // R4
  int_zero_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_int_vld |-> (int'(rel_idx) != ZERO_REG) && (int'(rel_idx) < INT_PHYS));

  // R4
  fp_zero_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_fp_vld |-> (int'(rel_idx) != ZERO_REG + INT_PHYS) && (int'(rel_idx) >= INT_PHYS));

endmodule

// File: rtl/regfree_pool.sv
`timescale 1ns/1ps
module regfree_pool #(
  parameter int DEPTH     = 16,
  parameter int IDX_W     = 5,
  parameter int INIT_BASE = 8,
  parameter int INIT_CNT  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           alloc_req,
  output logic [IDX_W-1:0]               alloc_idx,
  output logic                           not_empty,
  output logic [$clog2(DEPTH+1)-1:0]     free_cnt,
  input  logic                           push0_vld,
  input  logic [IDX_W-1:0]               push0_idx,
  input  logic                           push1_vld,
  input  logic [IDX_W-1:0]               push1_idx,
  output logic                           underflow_err,
  output logic                           overflow_err
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] WR_RST = PTR_W'(INIT_CNT % DEPTH);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [IDX_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d, wr1_ptr;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             uf_q, uf_d, of_q, of_d;
  logic             pop, acc0, acc1;
  logic [CNT_W:0]   space;

  // Next-state logic
  always_comb begin
    pop   = alloc_req && (cnt_q != '0);
    space = (CNT_W+1)'(DEPTH) - {1'b0, cnt_q} + (CNT_W+1)'(pop);
    acc0  = push0_vld && (space >= (CNT_W+1)'(1));
    acc1  = push1_vld && (acc0 ? (space >= (CNT_W+1)'(2))
                               : (space >= (CNT_W+1)'(1)));
    wr1_ptr = acc0 ? ptr_inc(wr_q) : wr_q;
    if (acc0 && acc1)      wr_d = ptr_inc(ptr_inc(wr_q));
    else if (acc0 || acc1) wr_d = ptr_inc(wr_q);
    else                   wr_d = wr_q;
    rd_d  = pop ? ptr_inc(rd_q) : rd_q;
    cnt_d = CNT_W'({1'b0, cnt_q} + (CNT_W+1)'(acc0) + (CNT_W+1)'(acc1)
                   - (CNT_W+1)'(pop));
    uf_d  = uf_q || (alloc_req && (cnt_q == '0));
    of_d  = of_q || (push0_vld && !acc0) || (push1_vld && !acc1);
  end

  // Storage: one register per entry with its own write enable
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic [IDX_W-1:0] RST_VAL = (i < INIT_CNT) ? IDX_W'(INIT_BASE + i) : '0;
    logic             we;
    logic [IDX_W-1:0] wdata;

    always_comb begin
      we    = (acc0 && (wr_q == PTR_W'(i))) || (acc1 && (wr1_ptr == PTR_W'(i)));
      wdata = (acc1 && (wr1_ptr == PTR_W'(i))) ? push1_idx : push0_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[i] <= RST_VAL;
      end else if (we) begin
        mem_q[i] <= wdata;
      end
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= WR_RST;
      cnt_q <= CNT_W'(INIT_CNT);
      uf_q  <= 1'b0;
      of_q  <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
      uf_q  <= uf_d;
      of_q  <= of_d;
    end
  end

  assign alloc_idx     = mem_q[rd_q];
  assign not_empty     = (cnt_q != '0);
  assign free_cnt      = cnt_q;
  assign underflow_err = uf_q;
  assign overflow_err  = of_q;

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CNT_W'(DEPTH));

  // R8
  empty_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !not_empty && !push0_vld && !push1_vld)
      |=> (free_cnt == '0) && underflow_err);

  // R8
  uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);

  // R9
  of_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);

  // R9
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == CNT_W'(DEPTH) && !alloc_req && push0_vld)
      |=> overflow_err && (free_cnt == CNT_W'(DEPTH)));

  // R10
  swap_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && not_empty && (push0_vld != push1_vld)) |=> $stable(free_cnt));

endmodule

// File: rtl/regfree_list.sv
`timescale 1ns/1ps
module regfree_list #(
  parameter int INT_PHYS = 16,
  parameter int INT_LOG  = 8,
  parameter int FP_PHYS  = 12,
  parameter int FP_LOG   = 6,
  parameter int ZERO_REG = 0,
  parameter int IDX_W    = $clog2(INT_PHYS + FP_PHYS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            int_alloc_req,
  output logic [IDX_W-1:0]                int_alloc_idx,
  input  logic                            fp_alloc_req,
  output logic [IDX_W-1:0]                fp_alloc_idx,
  input  logic                            rel_vld,
  input  logic [IDX_W-1:0]                rel_idx,
  input  logic                            int_rel_vld,
  input  logic [IDX_W-1:0]                int_rel_idx,
  input  logic                            fp_rel_vld,
  input  logic [IDX_W-1:0]                fp_rel_idx,
  output logic                            int_not_empty,
  output logic [$clog2(INT_PHYS+1)-1:0]   int_free_cnt,
  output logic                            fp_not_empty,
  output logic [$clog2(FP_PHYS+1)-1:0]    fp_free_cnt,
  output logic                            underflow_err,
  output logic                            overflow_err
);

  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       g_to_int, g_to_fp;
  logic       int_uf, int_of, fp_uf, fp_of;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  regfree_router #(
    .IDX_W(IDX_W), .INT_PHYS(INT_PHYS), .FP_PHYS(FP_PHYS), .ZERO_REG(ZERO_REG)
  ) u_router (
    .clk(clk), .rst_n(core_rst_n),
    .rel_vld(rel_vld), .rel_idx(rel_idx),
    .to_int_vld(g_to_int), .to_fp_vld(g_to_fp)
  );

  regfree_pool #(
    .DEPTH(INT_PHYS), .IDX_W(IDX_W), .INIT_BASE(INT_LOG), .INIT_CNT(INT_PHYS - INT_LOG)
  ) u_int_pool (
    .clk(clk), .rst_n(core_rst_n),
    .alloc_req(int_alloc_req), .alloc_idx(int_alloc_idx),
    .not_empty(int_not_empty), .free_cnt(int_free_cnt),
    .push0_vld(g_to_int), .push0_idx(rel_idx),
    .push1_vld(int_rel_vld), .push1_idx(int_rel_idx),
    .underflow_err(int_uf), .overflow_err(int_of)
  );

  regfree_pool #(
    .DEPTH(FP_PHYS), .IDX_W(IDX_W), .INIT_BASE(INT_PHYS + FP_LOG), .INIT_CNT(FP_PHYS - FP_LOG)
  ) u_fp_pool (
    .clk(clk), .rst_n(core_rst_n),
    .alloc_req(fp_alloc_req), .alloc_idx(fp_alloc_idx),
    .not_empty(fp_not_empty), .free_cnt(fp_free_cnt),
    .push0_vld(g_to_fp), .push0_idx(rel_idx),
    .push1_vld(fp_rel_vld), .push1_idx(fp_rel_idx),
    .underflow_err(fp_uf), .overflow_err(fp_of)
  );

  assign underflow_err = int_uf || fp_uf;
  assign overflow_err  = int_of || fp_of;

endmodule

// File: tb/tb_regfree_list.sv
`timescale 1ns/1ps
module tb_regfree_list;

  localparam int INT_PHYS = 16;
  localparam int INT_LOG  = 8;
  localparam int FP_PHYS  = 12;
  localparam int FP_LOG   = 6;
  localparam int IDX_W    = 5;
  localparam int TOTAL    = INT_PHYS + FP_PHYS;

  logic clk = 1'b0;
  logic rst_n;
  logic int_alloc_req, fp_alloc_req, rel_vld, int_rel_vld, fp_rel_vld;
  logic [IDX_W-1:0] rel_idx, int_rel_idx, fp_rel_idx, int_alloc_idx, fp_alloc_idx;
  logic int_not_empty, fp_not_empty, underflow_err, overflow_err;
  logic [4:0] int_free_cnt;
  logic [3:0] fp_free_cnt;

  always #2 clk = ~clk;

  regfree_list dut (
    .clk(clk), .rst_n(rst_n),
    .int_alloc_req(int_alloc_req), .int_alloc_idx(int_alloc_idx),
    .fp_alloc_req(fp_alloc_req), .fp_alloc_idx(fp_alloc_idx),
    .rel_vld(rel_vld), .rel_idx(rel_idx),
    .int_rel_vld(int_rel_vld), .int_rel_idx(int_rel_idx),
    .fp_rel_vld(fp_rel_vld), .fp_rel_idx(fp_rel_idx),
    .int_not_empty(int_not_empty), .int_free_cnt(int_free_cnt),
    .fp_not_empty(fp_not_empty), .fp_free_cnt(fp_free_cnt),
    .underflow_err(underflow_err), .overflow_err(overflow_err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  string tag   = "R1";

  int int_q[$];
  int fp_q[$];
  bit m_uf = 0, m_of = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(tag, "int_free_cnt", int'(int_free_cnt), int_q.size());
    check(tag, "int_not_empty", int'(int_not_empty), int'(int_q.size() != 0));
    if (int_q.size() != 0) check(tag, "int_alloc_idx", int'(int_alloc_idx), int_q[0]);
    check(tag, "fp_free_cnt", int'(fp_free_cnt), fp_q.size());
    check(tag, "fp_not_empty", int'(fp_not_empty), int'(fp_q.size() != 0));
    if (fp_q.size() != 0) check(tag, "fp_alloc_idx", int'(fp_alloc_idx), fp_q[0]);
    check(tag, "underflow_err", int'(underflow_err), int'(m_uf));
    check(tag, "overflow_err", int'(overflow_err), int'(m_of));
  endtask

  function automatic void push_int(input int v);
    if (int_q.size() < INT_PHYS) int_q.push_back(v); else m_of = 1;
  endfunction

  function automatic void push_fp(input int v);
    if (fp_q.size() < FP_PHYS) fp_q.push_back(v); else m_of = 1;
  endfunction

  // Drive one cycle of stimulus at the falling edge, update the model at the
  // rising edge, and compare at the next falling edge.
  task automatic step(input bit ia, input bit fa,
                      input bit rv, input int ri,
                      input bit iv, input int ii,
                      input bit fv, input int fi);
    int_alloc_req = ia; fp_alloc_req = fa;
    rel_vld = rv;       rel_idx = IDX_W'(ri);
    int_rel_vld = iv;   int_rel_idx = IDX_W'(ii);
    fp_rel_vld = fv;    fp_rel_idx = IDX_W'(fi);
    @(posedge clk);
    if (ia) begin
      if (int_q.size() > 0) void'(int_q.pop_front()); else m_uf = 1;
    end
    if (fa) begin
      if (fp_q.size() > 0) void'(fp_q.pop_front()); else m_uf = 1;
    end
    if (rv) begin
      if (ri < INT_PHYS) begin
        if (ri != 0) push_int(ri);
      end else if (ri < TOTAL) begin
        if (ri != INT_PHYS) push_fp(ri);
      end
    end
    if (iv) push_int(ii);
    if (fv) push_fp(fi);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    int_alloc_req = 0; fp_alloc_req = 0; rel_vld = 0; rel_idx = '0;
    int_rel_vld = 0; int_rel_idx = '0; fp_rel_vld = 0; fp_rel_idx = '0;
    for (int i = INT_LOG; i < INT_PHYS; i++) int_q.push_back(i);
    for (int i = INT_PHYS + FP_LOG; i < TOTAL; i++) fp_q.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, fixed expectations
    tag = "R1";
    compare_all();
    check("R1", "int count after reset", int'(int_free_cnt), 8);
    check("R1", "int first index", int'(int_alloc_idx), 8);
    check("R1", "fp count after reset", int'(fp_free_cnt), 6);
    check("R1", "fp first index", int'(fp_alloc_idx), 22);

    // R2 FIFO allocation order
    tag = "R2";
    repeat (3) step(1, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) step(0, 1, 0, 0, 0, 0, 0, 0);
    check("R2", "int index after three allocs", int'(int_alloc_idx), 11);
    check("R2", "fp index after two allocs", int'(fp_alloc_idx), 24);

    // R3 routing by value, out of range ignored
    tag = "R3";
    step(0, 0, 1, 3, 0, 0, 0, 0);
    step(0, 0, 1, 20, 0, 0, 0, 0);
    step(0, 0, 1, 29, 0, 0, 0, 0);
    step(0, 0, 1, 31, 0, 0, 0, 0);
    check("R3", "int count after routing", int'(int_free_cnt), 6);
    check("R3", "fp count after routing", int'(fp_free_cnt), 5);

    // R4 zero registers dropped on the generic port
    tag = "R4";
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 16, 0, 0, 0, 0);
    check("R4", "int count after zero release", int'(int_free_cnt), 6);
    check("R4", "fp count after zero release", int'(fp_free_cnt), 5);

    // R5 direct ports are unfiltered
    tag = "R5";
    step(0, 0, 0, 0, 1, 0, 1, 16);
    step(0, 0, 0, 0, 1, 25, 1, 2);
    check("R5", "int count after direct pushes", int'(int_free_cnt), 8);
    check("R5", "fp count after direct pushes", int'(fp_free_cnt), 7);

    // R6 generic ahead of direct in the same cycle
    tag = "R6";
    step(0, 0, 1, 5, 1, 6, 0, 0);
    step(0, 0, 1, 18, 0, 0, 1, 19);
    // R10 allocate and release together
    tag = "R10";
    step(1, 0, 1, 7, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 1, 21);
    check("R10", "int count unchanged by swap", int'(int_free_cnt), 10);

    // Drain int pool and confirm R6 order: ... 3, 0, 25, 5, 6, 7
    tag = "R6";
    while (int_q.size() > 3) step(1, 0, 0, 0, 0, 0, 0, 0);
    check("R6", "generic entry first", int'(int_alloc_idx), 5);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    check("R6", "direct entry second", int'(int_alloc_idx), 6);

    // R8 allocate from empty floating-point pool
    tag = "R8";
    while (fp_q.size() > 0) step(0, 1, 0, 0, 0, 0, 0, 0);
    check("R8", "fp empty flag", int'(fp_not_empty), 0);
    check("R8", "no error before empty alloc", int'(underflow_err), 0);
    step(0, 1, 0, 0, 0, 0, 0, 0);
    check("R8", "underflow raised", int'(underflow_err), 1);
    check("R8", "fp count still zero", int'(fp_free_cnt), 0);
    // R10 empty pool: release is not handed out in the same cycle
    tag = "R10";
    step(0, 1, 0, 0, 0, 0, 1, 23);
    check("R10", "fp count after empty swap", int'(fp_free_cnt), 1);
    check("R10", "fp front is released index", int'(fp_alloc_idx), 23);

    // R9 double free into a nearly full integer pool
    tag = "R9";
    while (int_q.size() < INT_PHYS - 1) step(0, 0, 0, 0, 1, 9, 0, 0);
    check("R9", "no overflow before full", int'(overflow_err), 0);
    step(0, 0, 1, 4, 1, 12, 0, 0);
    check("R9", "overflow raised", int'(overflow_err), 1);
    check("R9", "int count at capacity", int'(int_free_cnt), INT_PHYS);
    repeat (2) idle();

    // R7 random mixed traffic
    tag = "R7";
    for (int c = 0; c < 3000; c++) begin
      step(($urandom % 3) == 0, ($urandom % 3) == 0,
           ($urandom % 2) == 0, int'($urandom % 32),
           ($urandom % 5) == 0, int'($urandom % 32),
           ($urandom % 5) == 0, int'($urandom % 32));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule